// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a guest I/O instruction must be handed back to the hypervisor. It uses an I/O permission bitmap held in external memory, with one bit for each port number. A caller pulses `start_i` and presents four things: the 16-bit port number, the access-info word, the address of the next instruction and the I/O-intercept enable.

When the intercept is off, the block answers at once without touching memory. When it is on, the block fetches one 16-bit word from the bitmap. It then tests a run of consecutive bits. The run is as long as the access size field says and starts at the port's bit position inside its byte. Because the fetch is 16 bits wide, an access whose run spills into the next bitmap byte is still checked in full.

On an exit the block returns two words for the exit record. The first packs the port number with the access-info word. The second is the next-instruction address.

Top module: `io_perm_check`

## Requirements
- R1: With `intercept_en_i` low at an accepted start, `mem_req_o` stays low, `done_o` is high in the cycle after start, and `exit_o`, `exit_info1_o` and `exit_info2_o` are zero.
- R2: With the intercept on, `mem_req_o` rises in the cycle after start. `mem_addr_o` equals `map_base_i + (port_i >> 3)`, computed as a full 64-bit sum, so a carry out of the low 32 bits is kept.
- R3: The size field is bits 6:4 of the access-info word. The run mask is `(1 << size) - 1`. The fetched word is little-endian: `mem_rdata_i[7:0]` is the byte at `mem_addr_o` and `mem_rdata_i[15:8]` is the byte after it. The block exits when `mem_rdata_i & (mask << port[2:0])` is nonzero.
- R4: On an exit, `exit_info1_o` equals the access-info word, zero-extended to 64 bits, ORed with the port shifted left by 16. Without an exit, both exit-info outputs are zero.
- R5: On an exit, `exit_info2_o` equals the next-instruction address captured at start.
- R6: `mem_req_o` is held high, with a stable address, until `mem_rvalid_i` is seen. `done_o` is high in the cycle after the cycle in which `mem_rvalid_i` is sampled.
- R7: `done_o` is high for exactly one cycle. `exit_o` and both exit-info outputs keep their values until the next accepted start.
- R8: A `start_i` pulse while a check is in progress is ignored. The result depends only on the inputs captured at the accepted start.
- R9: A size field of zero never causes an exit, even when every bitmap bit is set.
- R10: A run that starts at bit offset 6 or 7 and crosses into the upper byte of the fetched word exits on a set bit in that upper byte alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a check (accepted only when idle) |
| port_i | input | 16 | I/O port number |
| info_i | input | 32 | Access-info word; bits 6:4 give the access size |
| next_ip_i | input | 64 | Address of the next instruction |
| intercept_en_i | input | 1 | I/O intercept enable |
| map_base_i | input | 64 | Base address of the permission bitmap |
| mem_req_o | output | 1 | Bitmap read request, held until `mem_rvalid_i` |
| mem_addr_o | output | 64 | Byte address of the low byte of the 16-bit fetch |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Fetched bitmap word, little-endian |
| done_o | output | 1 | One-cycle completion pulse |
| exit_o | output | 1 | The access must exit |
| exit_info1_o | output | 64 | Port and access-info record |
| exit_info2_o | output | 64 | Next-instruction address record |

## Verification
The bench builds the block with its default parameters: a 16-bit port, a 32-bit info word, 64-bit addresses and a 3-bit size field at bit 4. These widths make the whole size range 0..7 reachable, together with every byte offset. They also let the bench drive the highest port number, 0xFFFF, against a map base whose sum carries past bit 32. Random read latencies of 0 to 3 cycles exercise the held request. Start pulses inserted during a pending read, with scrambled inputs, probe whether the captured inputs stay in use.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } perm_st_e;

    localparam int FETCH_W   = 16;
    localparam int BYTE_BITS = 3;

endpackage

// File: rtl/io_perm_window.sv
module io_perm_window #(
    parameter int FETCH_W = 16,
    parameter int OFS_W   = 3,
    parameter int SIZE_W  = 3
) (
    input  logic [OFS_W-1:0]   ofs_i,
    input  logic [SIZE_W-1:0]  size_i,
    input  logic [FETCH_W-1:0] word_i,
    output logic               hit_o
);

    logic [FETCH_W-1:0] sel;

    for (genvar b = 0; b < FETCH_W; b++) begin : g_sel
        assign sel[b] = (b >= int'(ofs_i)) && (b < int'(ofs_i) + int'(size_i));
    end

    assign hit_o = |(word_i & sel);

    always_comb begin
        if (size_i == '0) begin
            a_r9_zero_size_no_hit: assert (!hit_o);
        end
    end

endmodule

// File: rtl/io_perm_addr.sv
module io_perm_addr #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 13
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  byte_idx_i,
    output logic [ADDR_W-1:0] addr_o
);

    assign addr_o = base_i + ADDR_W'(byte_idx_i);

endmodule

// File: rtl/io_perm_ctrl.sv
module io_perm_ctrl
    import io_perm_pkg::*;
#(
    parameter int PORT_W     = 16,
    parameter int INFO_W     = 32,
    parameter int ADDR_W     = 64,
    parameter int IP_W       = 64,
    parameter int EI_W       = 64,
    parameter int PORT_SHIFT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic [INFO_W-1:0] info_i,
    input  logic [IP_W-1:0]   next_ip_i,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              rvalid_i,
    input  logic              win_hit_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    output logic              mem_req_o,
    output logic [PORT_W-1:0] cap_port_o,
    output logic [INFO_W-1:0] cap_info_o,
    output logic [ADDR_W-1:0] cap_base_o,
    output logic              done_o,
    output logic              exit_o,
    output logic [EI_W-1:0]   info1_o,
    output logic [IP_W-1:0]   info2_o
);

    typedef struct packed {
        perm_st_e          st;
        logic [PORT_W-1:0] port;
        logic [INFO_W-1:0] info;
        logic [IP_W-1:0]   nip;
        logic [ADDR_W-1:0] base;
        logic              hit;
        logic [EI_W-1:0]   ei1;
        logic [IP_W-1:0]   ei2;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.port = port_i;
                    d.info = info_i;
                    d.nip  = next_ip_i;
                    d.base = base_i;
                    d.hit  = 1'b0;
                    d.ei1  = '0;
                    d.ei2  = '0;
                    d.st   = en_i ? ST_WAIT : ST_DONE;
                end
            end
            ST_WAIT: begin
                if (rvalid_i) begin
                    d.hit = win_hit_i;
                    if (win_hit_i) begin
                        d.ei1 = EI_W'(q.info) | (EI_W'(q.port) << PORT_SHIFT);
                        d.ei2 = q.nip;
                    end
                    d.st = ST_DONE;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_req_o  = (q.st == ST_WAIT);
    assign done_o     = (q.st == ST_DONE);
    assign exit_o     = q.hit;
    assign info1_o    = q.ei1;
    assign info2_o    = q.ei2;
    assign cap_port_o = q.port;
    assign cap_info_o = q.info;
    assign cap_base_o = q.base;

    a_r1_disabled_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start_i && !en_i) |=> (done_o && !mem_req_o && !exit_o));

    a_r6_done_after_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && rvalid_i) |=> done_o);

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !rvalid_i) |=> (mem_req_o && $stable(mem_addr_i)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r4_clean_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exit_o) |-> (info1_o == '0 && info2_o == '0));

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !mem_req_o && !$past(start_i)) |-> $stable(exit_o));

endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
    import io_perm_pkg::*;
#(
    parameter int PORT_W     = 16,
    parameter int INFO_W     = 32,
    parameter int ADDR_W     = 64,
    parameter int IP_W       = 64,
    parameter int EI_W       = 64,
    parameter int SIZE_LSB   = 4,
    parameter int SIZE_W     = 3,
    parameter int PORT_SHIFT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       port_i,
    input  logic [31:0]       info_i,
    input  logic [63:0]       next_ip_i,
    input  logic              intercept_en_i,
    input  logic [63:0]       map_base_i,
    output logic              mem_req_o,
    output logic [63:0]       mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [15:0]       mem_rdata_i,
    output logic              done_o,
    output logic              exit_o,
    output logic [63:0]       exit_info1_o,
    output logic [63:0]       exit_info2_o
);

    localparam int IDX_W = PORT_W - BYTE_BITS;

    logic [PORT_W-1:0] cap_port;
    logic [INFO_W-1:0] cap_info;
    logic [ADDR_W-1:0] cap_base;
    logic              win_hit;

    io_perm_ctrl #(
        .PORT_W(PORT_W), .INFO_W(INFO_W), .ADDR_W(ADDR_W),
        .IP_W(IP_W), .EI_W(EI_W), .PORT_SHIFT(PORT_SHIFT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .port_i     (port_i),
        .info_i     (info_i),
        .next_ip_i  (next_ip_i),
        .en_i       (intercept_en_i),
        .base_i     (map_base_i),
        .rvalid_i   (mem_rvalid_i),
        .win_hit_i  (win_hit),
        .mem_addr_i (mem_addr_o),
        .mem_req_o  (mem_req_o),
        .cap_port_o (cap_port),
        .cap_info_o (cap_info),
        .cap_base_o (cap_base),
        .done_o     (done_o),
        .exit_o     (exit_o),
        .info1_o    (exit_info1_o),
        .info2_o    (exit_info2_o)
    );

    io_perm_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .base_i     (cap_base),
        .byte_idx_i (cap_port[PORT_W-1:BYTE_BITS]),
        .addr_o     (mem_addr_o)
    );

    io_perm_window #(.FETCH_W(FETCH_W), .OFS_W(BYTE_BITS), .SIZE_W(SIZE_W)) u_win (
        .ofs_i  (cap_port[BYTE_BITS-1:0]),
        .size_i (cap_info[SIZE_LSB +: SIZE_W]),
        .word_i (mem_rdata_i),
        .hit_o  (win_hit)
    );

endmodule

// File: tb/io_perm_check_tb.sv
module io_perm_check_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] port_i = '0;
    logic [31:0] info_i = '0;
    logic [63:0] next_ip_i = '0;
    logic        intercept_en_i = 1'b0;
    logic [63:0] map_base_i = '0;
    logic        mem_req_o;
    logic [63:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [15:0] mem_rdata_i = '0;
    logic        done_o;
    logic        exit_o;
    logic [63:0] exit_info1_o;
    logic [63:0] exit_info2_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    io_perm_check u_dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic want_exit(input logic [15:0] p, input logic [31:0] inf,
                                       input logic [15:0] w);
        logic [15:0] run;
        run = (16'd1 << inf[6:4]) - 16'd1;
        return |(w & (run << p[2:0]));
    endfunction

    task automatic txn(input logic [15:0] p, input logic [31:0] inf, input logic [63:0] nip,
                       input logic en, input logic [63:0] base, input logic [15:0] w,
                       input int dly, input bit poke);
        logic        hit;
        logic [63:0] e1, e2;
        hit = en && want_exit(p, inf, w);
        e1  = hit ? ({32'd0, inf} | ({48'd0, p} << 16)) : 64'd0;
        e2  = hit ? nip : 64'd0;
        @(negedge clk);
        start_i = 1'b1; port_i = p; info_i = inf; next_ip_i = nip;
        intercept_en_i = en; map_base_i = base;
        @(negedge clk);
        start_i = 1'b0;
        if (en) begin
            chk("R2 req raised", {63'd0, mem_req_o}, 64'd1);
            chk("R2 address", mem_addr_o, base + {51'd0, p[15:3]});
            for (int k = 0; k < dly; k++) begin
                start_i = poke; port_i = ~p; info_i = ~inf; next_ip_i = ~nip;
                map_base_i = ~base; intercept_en_i = 1'b0;
                @(negedge clk);
                start_i = 1'b0;
                chk("R6 req held", {63'd0, mem_req_o}, 64'd1);
                if (poke) chk("R8 addr unchanged", mem_addr_o, base + {51'd0, p[15:3]});
            end
            mem_rvalid_i = 1'b1; mem_rdata_i = w;
            @(negedge clk);
            mem_rvalid_i = 1'b0; mem_rdata_i = 16'($urandom());
        end else begin
            chk("R1 no read", {63'd0, mem_req_o}, 64'd0);
        end
        chk(en ? "R6 done timing" : "R1 done timing", {63'd0, done_o}, 64'd1);
        chk("R3 exit decision", {63'd0, exit_o}, {63'd0, hit});
        chk("R4 exit info 1", exit_info1_o, e1);
        chk("R5 exit info 2", exit_info2_o, e2);
        @(negedge clk);
        chk("R7 done single", {63'd0, done_o}, 64'd0);
        chk("R7 exit held", {63'd0, exit_o}, {63'd0, hit});
        chk("R7 info1 held", exit_info1_o, e1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R7 reset done", {63'd0, done_o}, 64'd0);
        chk("R1 reset req", {63'd0, mem_req_o}, 64'd0);
        chk("R4 reset info1", exit_info1_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: disabled intercept never exits
        txn(16'h0060, 32'h0000_0070, 64'h1000, 1'b0, 64'h8000, 16'hFFFF, 0, 1'b0);
        // R10: run at offset 6, size 4, only the upper byte bit 0 set
        txn(16'h0006, 32'h0000_0040, 64'h2222, 1'b1, 64'h4000, 16'h0100, 0, 1'b0);
        chk("R10 crossing exit", {63'd0, exit_o}, 64'd1);
        // R9: zero size with a full bitmap word
        txn(16'h0013, 32'h0000_0008, 64'h3333, 1'b1, 64'h4000, 16'hFFFF, 1, 1'b0);
        chk("R9 zero size", {63'd0, exit_o}, 64'd0);
        // R2: top port with carry past bit 32
        txn(16'hFFFF, 32'h0000_0010, 64'hDEAD_BEEF, 1'b1, 64'h0000_0000_FFFF_F000, 16'h0080, 2, 1'b0);
        chk("R4 top port info1", exit_info1_o, 64'h0000_0000_FFFF_0010);
        // R4: upper info bits overlap the shifted port
        txn(16'h1234, 32'hABCD_0020, 64'h77, 1'b1, 64'h0, 16'h0030, 0, 1'b0);
        // R8: start pulses while waiting
        txn(16'h03F8, 32'h0000_0010, 64'h5555, 1'b1, 64'h9000, 16'h0001, 3, 1'b1);
        chk("R8 busy ignored", exit_info2_o, 64'h5555);
        for (int i = 0; i < 300; i++) begin
            txn(16'($urandom()), $urandom(), {$urandom(), $urandom()},
                ($urandom() % 4) != 0, {$urandom(), $urandom()} & 64'hFFFF_FFFF_FFFF_F000,
                16'($urandom()), int'($urandom() % 4), ($urandom() % 5) == 0);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule